// File: doc/BRIEF.md
# Dual-issue in-order scoreboard

This block is the issue stage of a two-wide, statically scheduled, in-order pipeline. Each cycle it looks at the two oldest entries of the decode queue, slot 0 (older) and slot 1 (younger). It decides whether none, the older one, or both may leave the queue. Leaving the queue is signalled by `iss0` and `iss1`, which the queue uses to pop entries. An instruction that issues has its source registers read through four asynchronous register-file read ports. One cycle later its opcode, destination and operand values appear on a registered execution interface.

A per-register scoreboard of small countdown counters records destinations whose results are still in flight. The countdown length depends on the class of the producer. An instruction stalls while any register it names is in flight. Inside a pair, a dependence on the older instruction is allowed only when a bypass path can supply the value: the producer must be a single-cycle ALU operation and the consumer must sit in the younger slot. The execution interface then flags the operands that have to be taken from the bypass instead of the register file. Only one load/store pipe exists, and it can take a memory operation from either slot.

Class encoding on `q*_cls`: 0 = ALU, 1 = load, 2 = store, 3 = treated as ALU.

Top module: `dual_issue_sb`

## Requirements
- R1: `iss1` is never high unless `iss0` is high in the same cycle, so issue is in program order. When no hazard applies, both valid slots issue together.
- R2: `iss0` is high exactly when `q0_vld` is high and none of `q0_ra`, `q0_rb`, or (when `q0_wen` is 1) `q0_dst` is marked in flight.
- R3: A register written by an issued load (class 1) is in flight for the two cycles after issue, so a dependent instruction issues no earlier than the third cycle after it. A register written by any other class is never in flight after its issue cycle.
- R4: With both slots free of scoreboard hazards, slot 1 may read slot 0's destination (slot 0 has `q0_wen`=1) only if slot 0 is class 0 or 3. Otherwise only slot 0 issues. When the pair issues, `x1_fwd_a` and `x1_fwd_b` are 1 for each slot-1 source equal to slot 0's destination.
- R5: When both slots hold a memory instruction (class 1 or 2), at most slot 0 issues in that cycle.
- R6: When both slots have `wen`=1 and the same destination, at most slot 0 issues in that cycle.
- R7: The read addresses `rf_ra0/rf_rb0/rf_ra1/rf_rb1` follow the slot sources. On the cycle after an issue, `x*_vld` is 1 and `x*_op`, `x*_dst`, `x*_wen`, `x*_a`, `x*_b` hold the opcode, destination, write enable and register-file data of that instruction. `x*_vld` is 0 after a cycle without issue in that slot.
- R8: During and right after reset no register is in flight, and `x0_vld`, `x1_vld` and `lsu_vld` are 0.
- R9: On the cycle after an issue, `lsu_vld` is 1 if an issued instruction is class 1 or 2. `lsu_slot1` is 1 exactly when that memory instruction came from slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q0_vld | input | 1 | Slot 0 (older) holds an instruction |
| q0_op | input | OPW | Slot 0 opcode |
| q0_cls | input | 2 | Slot 0 class |
| q0_wen | input | 1 | Slot 0 writes a register |
| q0_dst | input | RW | Slot 0 destination |
| q0_ra | input | RW | Slot 0 source A |
| q0_rb | input | RW | Slot 0 source B |
| q1_vld | input | 1 | Slot 1 (younger) holds an instruction |
| q1_op | input | OPW | Slot 1 opcode |
| q1_cls | input | 2 | Slot 1 class |
| q1_wen | input | 1 | Slot 1 writes a register |
| q1_dst | input | RW | Slot 1 destination |
| q1_ra | input | RW | Slot 1 source A |
| q1_rb | input | RW | Slot 1 source B |
| iss0 | output | 1 | Slot 0 issues this cycle |
| iss1 | output | 1 | Slot 1 issues this cycle |
| rf_ra0 | output | RW | Read address, slot 0 source A |
| rf_rb0 | output | RW | Read address, slot 0 source B |
| rf_ra1 | output | RW | Read address, slot 1 source A |
| rf_rb1 | output | RW | Read address, slot 1 source B |
| rf_da0 | input | DW | Read data for rf_ra0 |
| rf_db0 | input | DW | Read data for rf_rb0 |
| rf_da1 | input | DW | Read data for rf_ra1 |
| rf_db1 | input | DW | Read data for rf_rb1 |
| x0_vld | output | 1 | Execution slot 0 valid |
| x0_op | output | OPW | Execution slot 0 opcode |
| x0_dst | output | RW | Execution slot 0 destination |
| x0_wen | output | 1 | Execution slot 0 write enable |
| x0_a | output | DW | Execution slot 0 operand A |
| x0_b | output | DW | Execution slot 0 operand B |
| x1_vld | output | 1 | Execution slot 1 valid |
| x1_op | output | OPW | Execution slot 1 opcode |
| x1_dst | output | RW | Execution slot 1 destination |
| x1_wen | output | 1 | Execution slot 1 write enable |
| x1_a | output | DW | Execution slot 1 operand A |
| x1_b | output | DW | Execution slot 1 operand B |
| x1_fwd_a | output | 1 | Slot 1 operand A comes from the slot 0 bypass |
| x1_fwd_b | output | 1 | Slot 1 operand B comes from the slot 0 bypass |
| lsu_vld | output | 1 | A memory instruction was issued |
| lsu_slot1 | output | 1 | That memory instruction came from slot 1 |

## Verification
The bench targets these corner cases:
- A load followed at once by its consumer. A countdown that is one cycle short would let the consumer issue too early; one that is one cycle long would add a needless stall.
- An ALU producer paired with its consumer. Without the bypass permission, a legal pair is serialized; with a broken forward flag, execution reads a stale register value.
- Two memory operations in one pair, and two writes to the same destination. Getting either wrong makes both leave together, which oversubscribes the single load/store pipe or lets an in-flight mark be overwritten.
- Pseudo-random pairs drawn from a small register set. These cover the case of a stalled older slot letting its younger neighbour slip past it.

// File: rtl/dual_issue_sb.sv
module dual_issue_sb #(
  parameter int NREG    = 16,
  parameter int DW      = 32,
  parameter int OPW     = 8,
  parameter int LAT_ALU = 1,
  parameter int LAT_LD  = 3,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(LAT_LD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           q0_vld,
  input  logic [OPW-1:0] q0_op,
  input  logic [1:0]     q0_cls,
  input  logic           q0_wen,
  input  logic [RW-1:0]  q0_dst,
  input  logic [RW-1:0]  q0_ra,
  input  logic [RW-1:0]  q0_rb,
  input  logic           q1_vld,
  input  logic [OPW-1:0] q1_op,
  input  logic [1:0]     q1_cls,
  input  logic           q1_wen,
  input  logic [RW-1:0]  q1_dst,
  input  logic [RW-1:0]  q1_ra,
  input  logic [RW-1:0]  q1_rb,
  output logic           iss0,
  output logic           iss1,
  output logic [RW-1:0]  rf_ra0,
  output logic [RW-1:0]  rf_rb0,
  output logic [RW-1:0]  rf_ra1,
  output logic [RW-1:0]  rf_rb1,
  input  logic [DW-1:0]  rf_da0,
  input  logic [DW-1:0]  rf_db0,
  input  logic [DW-1:0]  rf_da1,
  input  logic [DW-1:0]  rf_db1,
  output logic           x0_vld,
  output logic [OPW-1:0] x0_op,
  output logic [RW-1:0]  x0_dst,
  output logic           x0_wen,
  output logic [DW-1:0]  x0_a,
  output logic [DW-1:0]  x0_b,
  output logic           x1_vld,
  output logic [OPW-1:0] x1_op,
  output logic [RW-1:0]  x1_dst,
  output logic           x1_wen,
  output logic [DW-1:0]  x1_a,
  output logic [DW-1:0]  x1_b,
  output logic           x1_fwd_a,
  output logic           x1_fwd_b,
  output logic           lsu_vld,
  output logic           lsu_slot1
);

  logic [NREG-1:0] busy;

  wire mem0 = (q0_cls == 2'd1) || (q0_cls == 2'd2);
  wire mem1 = (q1_cls == 2'd1) || (q1_cls == 2'd2);
  wire alu0 = !mem0;
  wire [CW-1:0] hold0 = (q0_cls == 2'd1) ? CW'(LAT_LD - 1) : CW'(LAT_ALU - 1);
  wire [CW-1:0] hold1 = (q1_cls == 2'd1) ? CW'(LAT_LD - 1) : CW'(LAT_ALU - 1);

  wire hit_a = q0_wen && (q1_ra == q0_dst);
  wire hit_b = q0_wen && (q1_rb == q0_dst);

  wire free0 = !busy[q0_ra] && !busy[q0_rb] && !(q0_wen && busy[q0_dst]);
  wire free1 = !busy[q1_ra] && !busy[q1_rb] && !(q1_wen && busy[q1_dst]);
  wire pair_ok = !(mem0 && mem1)
              && !(q0_wen && q1_wen && (q0_dst == q1_dst))
              && !((hit_a || hit_b) && !alu0);

  assign iss0 = q0_vld && free0;
  assign iss1 = iss0 && q1_vld && free1 && pair_ok;

  assign rf_ra0 = q0_ra;
  assign rf_rb0 = q0_rb;
  assign rf_ra1 = q1_ra;
  assign rf_rb1 = q1_rb;

  for (genvar r = 0; r < NREG; r++) begin : g_sb
    logic [CW-1:0] left;
    assign busy[r] = (left != '0);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                      left <= '0;
      else if (iss0 && q0_wen && q0_dst == RW'(r))    left <= hold0;
      else if (iss1 && q1_wen && q1_dst == RW'(r))    left <= hold1;
      else if (left != '0)                             left <= left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      x0_vld    <= 1'b0;
      x1_vld    <= 1'b0;
      lsu_vld   <= 1'b0;
      lsu_slot1 <= 1'b0;
    end else begin
      x0_vld    <= iss0;
      x1_vld    <= iss1;
      lsu_vld   <= (iss0 && mem0) || (iss1 && mem1);
      lsu_slot1 <= iss1 && mem1;
    end

  always_ff @(posedge clk) begin
    if (iss0) begin
      x0_op  <= q0_op;
      x0_dst <= q0_dst;
      x0_wen <= q0_wen;
      x0_a   <= rf_da0;
      x0_b   <= rf_db0;
    end
    if (iss1) begin
      x1_op    <= q1_op;
      x1_dst   <= q1_dst;
      x1_wen   <= q1_wen;
      x1_a     <= rf_da1;
      x1_b     <= rf_db1;
      x1_fwd_a <= hit_a;
      x1_fwd_b <= hit_b;
    end
  end

  p_in_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> iss0);

  p_load_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && q0_wen && q0_cls == 2'd1) |=> !(iss0 && q0_ra == $past(q0_dst)));

  p_bypass_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1 && q0_wen && (q1_ra == q0_dst || q1_rb == q0_dst)) |-> (q0_cls == 2'd0 || q0_cls == 2'd3));

  p_one_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q0_cls[1] != q0_cls[0]) && (q1_cls[1] != q1_cls[0]) |-> !iss1);

  p_same_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q0_wen && q1_wen && q0_dst == q1_dst) |-> !iss1);

  p_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss0 |=> x0_vld && x0_a == $past(rf_da0) && x0_b == $past(rf_db0));

endmodule

// File: tb/dual_issue_sb_tb.sv
module dual_issue_sb_tb_top;
  localparam int N = 320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic q0_vld, q1_vld, q0_wen, q1_wen;
  logic [7:0] q0_op, q1_op;
  logic [1:0] q0_cls, q1_cls;
  logic [3:0] q0_dst, q0_ra, q0_rb, q1_dst, q1_ra, q1_rb;
  logic iss0, iss1;
  logic [3:0] rf_ra0, rf_rb0, rf_ra1, rf_rb1;
  logic [31:0] rf_da0, rf_db0, rf_da1, rf_db1;
  logic x0_vld, x0_wen, x1_vld, x1_wen, x1_fwd_a, x1_fwd_b, lsu_vld, lsu_slot1;
  logic [7:0] x0_op, x1_op;
  logic [3:0] x0_dst, x1_dst;
  logic [31:0] x0_a, x0_b, x1_a, x1_b;

  function automatic logic [31:0] rval(input logic [3:0] a);
    return 32'hC0DE_0000 | (32'(a) * 32'h0000_0111);
  endfunction
  assign rf_da0 = rval(rf_ra0);
  assign rf_db0 = rval(rf_rb0);
  assign rf_da1 = rval(rf_ra1);
  assign rf_db1 = rval(rf_rb1);

  dual_issue_sb dut_i (.*);

  logic [7:0] p_op [N];
  logic [1:0] p_cls [N];
  logic       p_wen [N];
  logic [3:0] p_dst [N], p_ra [N], p_rb [N];
  int cnt [16];
  int head, checks, errors, cyc;

  logic e0v, e1v, elv, els1, efa, efb;
  int e0i, e1i;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [1:0] c, input logic w,
                     input int d, input int a, input int b);
    p_op[i] = 8'(i); p_cls[i] = c; p_wen[i] = w;
    p_dst[i] = 4'(d); p_ra[i] = 4'(a); p_rb[i] = 4'(b);
  endtask

  task automatic drive();
    q0_vld = head < N; q1_vld = head + 1 < N;
    q0_op = '0; q0_cls = '0; q0_wen = 0; q0_dst = '0; q0_ra = '0; q0_rb = '0;
    q1_op = '0; q1_cls = '0; q1_wen = 0; q1_dst = '0; q1_ra = '0; q1_rb = '0;
    if (head < N) begin
      q0_op = p_op[head]; q0_cls = p_cls[head]; q0_wen = p_wen[head];
      q0_dst = p_dst[head]; q0_ra = p_ra[head]; q0_rb = p_rb[head];
    end
    if (head + 1 < N) begin
      q1_op = p_op[head+1]; q1_cls = p_cls[head+1]; q1_wen = p_wen[head+1];
      q1_dst = p_dst[head+1]; q1_ra = p_ra[head+1]; q1_rb = p_rb[head+1];
    end
  endtask

  function automatic bit is_mem(input logic [1:0] c);
    return c == 2'd1 || c == 2'd2;
  endfunction

  initial begin
    int s;
    bit g0, g1, memp, samed, rawp, rawbad, ldblk;
    string t1;
    checks = 0; errors = 0; head = 0; cyc = 0;
    e0v = 0; e1v = 0; elv = 0; els1 = 0; efa = 0; efb = 0; e0i = 0; e1i = 0;
    for (int r = 0; r < 16; r++) cnt[r] = 0;
    put(0, 2'd1, 1, 1, 2, 3);   put(1, 2'd0, 1, 4, 1, 5);
    put(2, 2'd0, 1, 5, 6, 7);   put(3, 2'd0, 1, 8, 5, 5);
    put(4, 2'd1, 1, 9, 10, 11); put(5, 2'd2, 0, 0, 10, 11);
    put(6, 2'd0, 1, 12, 13, 14); put(7, 2'd3, 1, 12, 0, 15);
    put(8, 2'd2, 0, 0, 13, 14); put(9, 2'd0, 1, 15, 13, 0);
    put(10, 2'd2, 1, 3, 6, 7);  put(11, 2'd0, 1, 2, 3, 6);
    s = 32'h1234_5678;
    for (int i = 12; i < N; i++) begin
      s = s * 1103515245 + 12345;
      put(i, 2'((s >>> 16) & 3), 1'((s >>> 18) & 1), (s >>> 19) & 7,
          (s >>> 22) & 7, (s >>> 25) & 7);
    end
    drive();
    repeat (2) @(negedge clk);
    chk(x0_vld == 0, "R8", "x0_vld in reset", 32'(x0_vld), 0);
    chk(x1_vld == 0, "R8", "x1_vld in reset", 32'(x1_vld), 0);
    chk(lsu_vld == 0, "R8", "lsu_vld in reset", 32'(lsu_vld), 0);
    rst_n = 1;
    #1;
    while (head < N && cyc < 5000) begin
      cyc++;
      g0 = 0; g1 = 0; memp = 0; samed = 0; rawp = 0; rawbad = 0; ldblk = 0;
      if (q0_vld) begin
        g0 = cnt[q0_ra] == 0 && cnt[q0_rb] == 0 && !(q0_wen && cnt[q0_dst] != 0);
        ldblk = (cnt[q0_ra] != 0 || cnt[q0_rb] != 0);
      end
      if (g0 && q1_vld) begin
        memp = is_mem(q0_cls) && is_mem(q1_cls);
        samed = q0_wen && q1_wen && q0_dst == q1_dst;
        rawp = q0_wen && (q1_ra == q0_dst || q1_rb == q0_dst);
        rawbad = rawp && is_mem(q0_cls);
        g1 = cnt[q1_ra] == 0 && cnt[q1_rb] == 0 && !(q1_wen && cnt[q1_dst] != 0)
             && !memp && !samed && !rawbad;
      end
      chk(rf_ra1 == q1_ra && rf_rb0 == q0_rb, "R7", "read address", 32'(rf_ra1), 32'(q1_ra));
      chk(iss0 == g0, ldblk ? "R3" : "R2", "iss0", 32'(iss0), 32'(g0));
      t1 = memp ? "R5" : samed ? "R6" : rawp ? "R4" : "R1";
      chk(iss1 == g1, t1, "iss1", 32'(iss1), 32'(g1));
      e0v = g0; e1v = g1; e0i = head; e1i = head + 1;
      elv = (g0 && is_mem(q0_cls)) || (g1 && is_mem(q1_cls));
      els1 = g1 && is_mem(q1_cls);
      efa = q0_wen && q1_ra == q0_dst;
      efb = q0_wen && q1_rb == q0_dst;
      for (int r = 0; r < 16; r++) if (cnt[r] > 0) cnt[r]--;
      if (g0 && q0_wen) cnt[q0_dst] = (q0_cls == 2'd1) ? 2 : 0;
      if (g1 && q1_wen) cnt[q1_dst] = (q1_cls == 2'd1) ? 2 : 0;
      head += int'(g0) + int'(g1);
      @(negedge clk);
      chk(x0_vld == e0v, "R7", "x0_vld", 32'(x0_vld), 32'(e0v));
      chk(x1_vld == e1v, "R7", "x1_vld", 32'(x1_vld), 32'(e1v));
      chk(lsu_vld == elv && lsu_slot1 == els1, "R9", "lsu_vld/lsu_slot1",
          {30'd0, lsu_vld, lsu_slot1}, {30'd0, elv, els1});
      if (e0v) begin
        chk(x0_op == p_op[e0i] && x0_dst == p_dst[e0i] && x0_wen == p_wen[e0i],
            "R7", "x0 op", 32'(x0_op), 32'(p_op[e0i]));
        chk(x0_a == rval(p_ra[e0i]) && x0_b == rval(p_rb[e0i]), "R7", "x0 operand a",
            x0_a, rval(p_ra[e0i]));
      end
      if (e1v) begin
        chk(x1_op == p_op[e1i] && x1_dst == p_dst[e1i] && x1_wen == p_wen[e1i],
            "R7", "x1 op", 32'(x1_op), 32'(p_op[e1i]));
        chk(x1_a == rval(p_ra[e1i]) && x1_b == rval(p_rb[e1i]), "R7", "x1 operand a",
            x1_a, rval(p_ra[e1i]));
        chk(x1_fwd_a == efa && x1_fwd_b == efb, "R4", "x1 forward flags",
            {30'd0, x1_fwd_a, x1_fwd_b}, {30'd0, efa, efb});
      end
      drive();
      #1;
    end
    if (head < N) chk(0, "R1", "watchdog: program not drained", 32'(head), N);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule